// File: doc/BRIEF.md
# Split Direct-Mapped Translation Lookaside Buffer

This block caches linear-to-physical page translations for a paging unit. It keeps two independent direct-mapped arrays. One serves data accesses and the other serves instruction fetches. A lookup presents a linear address together with write, user and code attributes, and it answers in the same cycle with a hit flag and a physical address. A miss hands the access over to an external table walker. The walker is outside this block.

The walker installs a translation through the fill port. It supplies the page number, the physical frame, the dirty and global bits taken from the page table entry, and the effective writable and user rights it worked out. Software-driven maintenance has three forms: a flush of every entry, a flush that spares global entries, and the invalidation of a single page.

A hit is never a license to skip protection. Every hit runs the full page permission check again. A write is allowed to hit only when the cached entry is already dirty. If either test fails, the lookup reports a miss, and the walker then raises the fault or sets the dirty bit.

Top module: `split_tlb`

## Requirements
- R1: After reset every entry of both arrays is invalid, so every lookup reports a miss.
- R2: The code attribute selects the array: code lookups and code fills (code=1) use only the instruction array, and data lookups and data fills (code=0) use only the data array.
- R3: Linear address bits [17:12] pick the slot and bits [31:18] form the tag. A lookup hits only on a valid slot whose stored tag equals the request tag. On a hit the physical address is the stored 20-bit frame in bits [31:12] with linear bits [11:0] below it.
- R4: A tag match hits only if the access is allowed, and a denied access reports a miss. A user access needs the page user right, and a user write also needs the page writable right. A supervisor read is always allowed. A supervisor write needs the page writable right only when write protect is set.
- R5: A write lookup hits only when the matching entry was filled with the dirty bit set. Read lookups ignore the dirty bit.
- R6: A fill replaces every flag of its slot (valid, tag, frame, dirty, global, writable, user). Nothing of the previous occupant survives.
- R7: A flush with the all-entries mode set invalidates every entry in both arrays, global or not.
- R8: A flush with the all-entries mode clear invalidates the non-global entries of both arrays and leaves the global entries hitting.
- R9: A single-page invalidate examines the addressed slot in both arrays and clears each one whose tag matches. Slots with another tag keep hitting.
- R10: A lookup is combinational on the stored state. Fills, flushes and invalidates become visible only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_laddr_i | input | 32 | Lookup linear address |
| lk_write_i | input | 1 | Lookup is a write |
| lk_user_i | input | 1 | Lookup is a user-level access |
| lk_code_i | input | 1 | Lookup is an instruction fetch |
| wp_i | input | 1 | Write protect for supervisor writes |
| lk_hit_o | output | 1 | Lookup hit |
| lk_paddr_o | output | 32 | Physical address on a hit |
| fill_i | input | 1 | Install a translation |
| fill_vpn_i | input | 20 | Linear page number of the fill |
| fill_frame_i | input | 20 | Physical frame number |
| fill_dirty_i | input | 1 | Dirty bit from the table entry |
| fill_global_i | input | 1 | Global bit from the table entry |
| fill_wr_i | input | 1 | Effective writable right |
| fill_usr_i | input | 1 | Effective user right |
| fill_code_i | input | 1 | Fill goes into the instruction array |
| flush_i | input | 1 | Flush request |
| flush_all_i | input | 1 | Flush also removes global entries |
| inval_i | input | 1 | Single-page invalidate |
| inval_vpn_i | input | 20 | Linear page number to invalidate |

## Verification
A stale valid bit, a wrong tag or a wrong frame shows up at the ports on the first lookup that reaches that slot. It appears as a hit that should be a miss, or as a physical address with the wrong upper bits. A lost or spurious global, dirty or rights flag stays hidden until a flush, a write or a user access reaches that slot. For that reason every fill in the bench is followed, in the next cycle, by lookups that exercise the flags involved. A maintenance operation that misses one array only shows when the other array is probed. So both arrays are checked after every flush and invalidate.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned PG_W   = ADDR_W - OFF_W;

  // Index into the 32-entry rights table: {req_user, req_write, pg_usr, pg_wr, wp}
  function automatic logic [31:0] build_rights_table();
    logic [31:0] t;
    for (int k = 0; k < 32; k++) begin
      logic wp, pw, pu, rw, ru;
      wp = k[0]; pw = k[1]; pu = k[2]; rw = k[3]; ru = k[4];
      if (ru) t[k] = pu && (!rw || pw);
      else    t[k] = !rw || !wp || pw;
    end
    return t;
  endfunction
endpackage

// File: rtl/tlb_perm.sv
module tlb_perm
  import tlb_pkg::*;
(
  input  logic req_write_i,
  input  logic req_user_i,
  input  logic pg_wr_i,
  input  logic pg_usr_i,
  input  logic wp_i,
  output logic ok_o
);
  localparam logic [31:0] RIGHTS = build_rights_table();

  logic [4:0] sel;
  assign sel  = {req_user_i, req_write_i, pg_usr_i, pg_wr_i, wp_i};
  assign ok_o = RIGHTS[sel];
endmodule

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_laddr_i,
  input  logic              lk_write_i,
  input  logic              lk_user_i,
  input  logic              wp_i,
  output logic              lk_hit_o,
  output logic [PG_W-1:0]   lk_frame_o,
  input  logic              fill_i,
  input  logic [PG_W-1:0]   fill_vpn_i,
  input  logic [PG_W-1:0]   fill_frame_i,
  input  logic              fill_dirty_i,
  input  logic              fill_global_i,
  input  logic              fill_wr_i,
  input  logic              fill_usr_i,
  input  logic              flush_i,
  input  logic              flush_all_i,
  input  logic              inval_i,
  input  logic [PG_W-1:0]   inval_vpn_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned TAG_W = PG_W - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic [PG_W-1:0]  frame;
    logic             wr;
    logic             usr;
    logic             dirty;
  } slot_t;

  logic [DEPTH-1:0] valid_q, glob_q;
  slot_t            slot_q [DEPTH];

  logic [IDX_W-1:0] lk_idx, fill_idx, inval_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag, inval_tag;

  assign lk_idx    = lk_laddr_i[OFF_W +: IDX_W];
  assign lk_tag    = lk_laddr_i[ADDR_W-1 -: TAG_W];
  assign fill_idx  = fill_vpn_i[IDX_W-1:0];
  assign fill_tag  = fill_vpn_i[PG_W-1 -: TAG_W];
  assign inval_idx = inval_vpn_i[IDX_W-1:0];
  assign inval_tag = inval_vpn_i[PG_W-1 -: TAG_W];

  slot_t lk_slot;
  logic  tag_hit, rights_ok;
  assign lk_slot = slot_q[lk_idx];
  assign tag_hit = valid_q[lk_idx] && (lk_slot.tag == lk_tag);

  tlb_perm i_perm (
    .req_write_i(lk_write_i),
    .req_user_i (lk_user_i),
    .pg_wr_i    (lk_slot.wr),
    .pg_usr_i   (lk_slot.usr),
    .wp_i       (wp_i),
    .ok_o       (rights_ok)
  );

  // write must miss on a clean page so the walker can set dirty
  assign lk_hit_o   = tag_hit && rights_ok && (!lk_write_i || lk_slot.dirty);
  assign lk_frame_o = lk_slot.frame;

  logic inval_match;
  assign inval_match = valid_q[inval_idx] && (slot_q[inval_idx].tag == inval_tag);

  // flags: maintenance first, fill last so a same-cycle fill wins its slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      glob_q  <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (flush_i && (flush_all_i || !glob_q[i])) valid_q[i] <= 1'b0;
        if (inval_i && inval_match && (IDX_W'(i) == inval_idx)) valid_q[i] <= 1'b0;
        if (fill_i && (IDX_W'(i) == fill_idx)) begin
          valid_q[i] <= 1'b1;
          glob_q[i]  <= fill_global_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) begin
      slot_q[fill_idx] <= '{tag: fill_tag, frame: fill_frame_i, wr: fill_wr_i,
                            usr: fill_usr_i, dirty: fill_dirty_i};
    end
  end

  p_fill_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> valid_q[$past(fill_idx)]);

  p_flush_all_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && flush_all_i && !fill_i) |=> (valid_q == '0));

  p_flush_keeps_global_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !flush_all_i && !fill_i && !inval_i) |=> (valid_q == $past(valid_q & glob_q)));

  p_inval_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inval_i && inval_match && !fill_i) |=> !valid_q[$past(inval_idx)]);

  p_write_needs_dirty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_hit_o && lk_write_i) |-> slot_q[lk_idx].dirty);
endmodule

// File: rtl/split_tlb.sv
module split_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lk_laddr_i,
  input  logic              lk_write_i,
  input  logic              lk_user_i,
  input  logic              lk_code_i,
  input  logic              wp_i,
  output logic              lk_hit_o,
  output logic [ADDR_W-1:0] lk_paddr_o,
  input  logic              fill_i,
  input  logic [PG_W-1:0]   fill_vpn_i,
  input  logic [PG_W-1:0]   fill_frame_i,
  input  logic              fill_dirty_i,
  input  logic              fill_global_i,
  input  logic              fill_wr_i,
  input  logic              fill_usr_i,
  input  logic              fill_code_i,
  input  logic              flush_i,
  input  logic              flush_all_i,
  input  logic              inval_i,
  input  logic [PG_W-1:0]   inval_vpn_i
);
  localparam int unsigned N_ARR = 2;  // 0: data, 1: instruction

  logic [N_ARR-1:0] arr_hit;
  logic [PG_W-1:0]  arr_frame [N_ARR];

  for (genvar g = 0; g < N_ARR; g++) begin : g_arr
    tlb_array #(.IDX_W(IDX_W)) i_array (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lk_laddr_i   (lk_laddr_i),
      .lk_write_i   (lk_write_i),
      .lk_user_i    (lk_user_i),
      .wp_i         (wp_i),
      .lk_hit_o     (arr_hit[g]),
      .lk_frame_o   (arr_frame[g]),
      .fill_i       (fill_i && (fill_code_i == 1'(g))),
      .fill_vpn_i   (fill_vpn_i),
      .fill_frame_i (fill_frame_i),
      .fill_dirty_i (fill_dirty_i),
      .fill_global_i(fill_global_i),
      .fill_wr_i    (fill_wr_i),
      .fill_usr_i   (fill_usr_i),
      .flush_i      (flush_i),
      .flush_all_i  (flush_all_i),
      .inval_i      (inval_i),
      .inval_vpn_i  (inval_vpn_i)
    );
  end

  assign lk_hit_o   = arr_hit[lk_code_i];
  assign lk_paddr_o = {arr_frame[lk_code_i], lk_laddr_i[OFF_W-1:0]};

  p_flush_all_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && flush_all_i && !fill_i) |=> !lk_hit_o);

  p_offset_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_paddr_o[OFF_W-1:0] == lk_laddr_i[OFF_W-1:0]));
endmodule

// File: tb/test_split_tlb.sv
`timescale 1ns/1ps
module test_split_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_laddr = '0;
  logic        lk_write = 0, lk_user = 0, lk_code = 0, wp = 0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic        fill = 0;
  logic [19:0] fill_vpn = '0, fill_frame = '0;
  logic        fill_dirty = 0, fill_global = 0, fill_wr = 0, fill_usr = 0, fill_code = 0;
  logic        flush = 0, flush_all = 0, inval = 0;
  logic [19:0] inval_vpn = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  split_tlb i_split_tlb (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_laddr_i(lk_laddr), .lk_write_i(lk_write), .lk_user_i(lk_user),
    .lk_code_i(lk_code), .wp_i(wp), .lk_hit_o(lk_hit), .lk_paddr_o(lk_paddr),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_frame_i(fill_frame),
    .fill_dirty_i(fill_dirty), .fill_global_i(fill_global), .fill_wr_i(fill_wr),
    .fill_usr_i(fill_usr), .fill_code_i(fill_code),
    .flush_i(flush), .flush_all_i(flush_all), .inval_i(inval), .inval_vpn_i(inval_vpn)
  );

  task automatic look(input logic [31:0] a, input logic w, u, c, p,
                      input bit exp_hit, input logic [31:0] exp_pa, input string req);
    @(negedge clk);
    lk_laddr = a; lk_write = w; lk_user = u; lk_code = c; wp = p;
    #1;
    checks++;
    if (lk_hit !== exp_hit || (exp_hit && lk_paddr !== exp_pa)) begin
      failures++;
      $display("FAIL %s addr=%h hit=%b paddr=%h expected hit=%b paddr=%h",
               req, a, lk_hit, lk_paddr, exp_hit, exp_pa);
    end
  endtask

  task automatic do_fill(input logic [19:0] vpn, frm, input logic d, g, w, u, c);
    @(negedge clk);
    fill = 1; fill_vpn = vpn; fill_frame = frm; fill_dirty = d;
    fill_global = g; fill_wr = w; fill_usr = u; fill_code = c;
    @(negedge clk);
    fill = 0;
  endtask

  task automatic do_flush(input logic all);
    @(negedge clk); flush = 1; flush_all = all;
    @(negedge clk); flush = 0; flush_all = 0;
  endtask

  task automatic do_inval(input logic [19:0] vpn);
    @(negedge clk); inval = 1; inval_vpn = vpn;
    @(negedge clk); inval = 0;
  endtask

  function automatic logic [19:0] vpn_of(int i);
    return {14'(i * 3 + 1), 6'(i)};
  endfunction
  function automatic logic [19:0] frm_of(int i, int c);
    return 20'(i * 7 + 'h100 + c * 'h5000);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int i = 0; i < 64; i += 9) begin
      look({vpn_of(i), 12'h0}, 0, 0, 0, 0, 0, '0, "R1 reset data");
      look({vpn_of(i), 12'h0}, 0, 0, 1, 0, 0, '0, "R1 reset code");
    end
    // R10: fill not visible before the edge
    @(negedge clk);
    fill = 1; fill_vpn = vpn_of(2); fill_frame = 20'h12345; fill_dirty = 1;
    fill_global = 0; fill_wr = 1; fill_usr = 1; fill_code = 0;
    lk_laddr = {vpn_of(2), 12'h0}; lk_write = 0; lk_user = 0; lk_code = 0; wp = 0;
    #1; checks++;
    if (lk_hit !== 1'b0) begin failures++; $display("FAIL R10 hit=%b expected 0", lk_hit); end
    @(negedge clk); fill = 0; #1; checks++;
    if (lk_hit !== 1'b1 || lk_paddr !== 32'h12345000) begin
      failures++; $display("FAIL R10 hit=%b paddr=%h expected 1 12345000", lk_hit, lk_paddr);
    end
    // R2/R3: fill all data slots, lookup
    for (int i = 0; i < 64; i++) do_fill(vpn_of(i), frm_of(i, 0), 1, 0, 1, 1, 0);
    for (int i = 0; i < 64; i++) begin
      logic [11:0] off = 12'((i * 37) & 'hfff);
      look({vpn_of(i), off}, 0, 0, 0, 0, 1, {frm_of(i, 0), off}, "R3 data hit");
      look({vpn_of(i), off}, 0, 0, 1, 0, 0, '0, "R2 code miss");
      look({vpn_of(i) + 20'h40, off}, 0, 0, 0, 0, 0, '0, "R3 tag mismatch");
    end
    for (int i = 0; i < 64; i++) do_fill(vpn_of(i), frm_of(i, 1), 1, 0, 1, 1, 1);
    for (int i = 0; i < 64; i += 5) begin
      look({vpn_of(i), 12'h abc}, 0, 0, 1, 0, 1, {frm_of(i, 1), 12'habc}, "R2 code hit");
      look({vpn_of(i), 12'h abc}, 0, 0, 0, 0, 1, {frm_of(i, 0), 12'habc}, "R2 data kept");
    end
    // R4/R5: permission and dirty sweep
    for (int k = 0; k < 64; k++) begin
      logic d = k[5], pw = k[0], pu = k[1], p = k[2], rw = k[3], ru = k[4];
      bit ok = ru ? (pu && (!rw || pw)) : (!rw || !p || pw);
      bit eh = ok && (!rw || d);
      do_fill(20'h3a005, 20'(k + 'h700), d, 0, pw, pu, 0);
      look({20'h3a005, 12'h010}, rw, ru, 0, p, eh, {20'(k + 'h700), 12'h010},
           (ok ? "R5 dirty rule" : "R4 rights rule"));
    end
    // R6: refill replaces flags
    do_fill(vpn_of(9), 20'haaaaa, 1, 1, 1, 1, 0);
    do_fill(vpn_of(9), 20'hbbbbb, 0, 0, 0, 1, 0);
    look({vpn_of(9), 12'h0}, 1, 0, 0, 0, 0, '0, "R6 old dirty gone");
    look({vpn_of(9), 12'h0}, 0, 1, 0, 0, 1, 32'hbbbbb000, "R6 new frame");
    look({vpn_of(9), 12'h0}, 1, 0, 0, 1, 0, '0, "R6 old writable gone");
    do_flush(0);
    look({vpn_of(9), 12'h0}, 0, 0, 0, 0, 0, '0, "R6 old global gone");
    // R8: normal flush spares global
    for (int i = 0; i < 64; i++) do_fill(vpn_of(i), frm_of(i, 0), 1, i[0] == 0, 1, 1, 0);
    for (int i = 0; i < 64; i++) do_fill(vpn_of(i), frm_of(i, 1), 1, i[0] == 1, 1, 1, 1);
    do_flush(0);
    for (int i = 0; i < 64; i++) begin
      look({vpn_of(i), 12'h4}, 0, 0, 0, 0, i[0] == 0, {frm_of(i, 0), 12'h4}, "R8 data");
      look({vpn_of(i), 12'h4}, 0, 0, 1, 0, i[0] == 1, {frm_of(i, 1), 12'h4}, "R8 code");
    end
    // R7: flush all
    do_flush(1);
    for (int i = 0; i < 64; i++) begin
      look({vpn_of(i), 12'h4}, 0, 0, 0, 0, 0, '0, "R7 data");
      look({vpn_of(i), 12'h4}, 0, 0, 1, 0, 0, '0, "R7 code");
    end
    // R9: single-page invalidate
    do_fill(20'h12345, 20'h00011, 1, 1, 1, 1, 0);
    do_fill(20'h12345, 20'h00022, 1, 1, 1, 1, 1);
    do_fill(20'h55506, 20'h00033, 1, 0, 1, 1, 0);
    do_inval(20'h12345);
    look(32'h12345000, 0, 0, 0, 0, 0, '0, "R9 data cleared");
    look(32'h12345000, 0, 0, 1, 0, 0, '0, "R9 code cleared");
    look(32'h55506008, 0, 0, 0, 0, 1, 32'h00033008, "R9 other slot kept");
    do_inval(20'h77706);
    look(32'h55506008, 0, 0, 0, 0, 1, 32'h00033008, "R9 tag mismatch kept");
    do_inval(20'h55506);
    look(32'h55506008, 0, 0, 0, 0, 0, '0, "R9 matching cleared");
    // R1: reset clears everything
    do_fill(20'h0000a, 20'h0000b, 1, 1, 1, 1, 1);
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    look(32'h0000a000, 0, 0, 1, 0, 0, '0, "R1 reset after fill");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule